// File: doc/BRIEF.md
# Serial Clock-Mask Loader

After a bridge reset this block fetches the secondary-clock disable mask from an external parallel-in/serial-out shift register. It borrows two general-purpose I/O pins for the fetch. One is the load/shift select and the other is a shift clock. The serial bit stream comes back on a third pin. The block captures the bits into a mask register and then gives all borrowed pins back to the ordinary GPIO registers. It holds the secondary bus in reset until the mask has been captured. After capture the mask register can be replaced through a configuration write.

A state machine steps through five states:

- `ST_IDLE` waits for the start condition.
- `ST_LOAD` pulses the load pin low.
- `ST_SHIFT_LO` and `ST_SHIFT_HI` form one period of the shift clock per mask bit.
- `ST_DONE` is terminal.

The transitions are:

- IDLE→LOAD when the sensed secondary reset is low.
- LOAD→SHIFT_LO always.
- SHIFT_LO→SHIFT_HI always, and this step captures one bit.
- SHIFT_HI→SHIFT_LO while fewer than `MASK_W` bits are held.
- SHIFT_HI→DONE once `MASK_W` bits are held.
- Primary reset returns the machine from any state to IDLE.

Top module: `clkmask_loader`

## Requirements
- R1: After primary reset is released, the block stays idle while `sec_rst_sense_n` is high. In idle, `busy`=0, `done`=0, the load pin is driven high and the shift-clock pin is driven low.
- R2: On the first clock edge that sees `sec_rst_sense_n` low while idle, the block drives the load pin (index `LD_PIN`) low. It holds it low for exactly one cycle and keeps it high from then on.
- R3: After the load cycle the shift-clock pin (index `SCLK_PIN`) is driven low for one cycle and then high for one cycle, repeatedly. It makes exactly `MASK_W` rising edges. `done` rises `2*MASK_W+1` cycles after the load cycle begins.
- R4: `ser_in` is sampled on the clock edge that raises the shift-clock pin. The first sampled bit lands in mask bit `MASK_W-1` and the last in bit 0.
- R5: Once `done`=1 it stays 1 and `busy`=0, and later changes on `ser_in` leave `clk_mask` unchanged.
- R6: `sec_rst_n` is 0 whenever `done`=0. Once `done`=1, `sec_rst_n` equals the inverse of `sw_sec_rst`.
- R7: While `done`=0, `gpio_oe` is 1 only at `LD_PIN` and `SCLK_PIN`. Once `done`=1, `gpio_out` equals `gpio_reg_out` and `gpio_oe` equals `gpio_reg_oe`.
- R8: Bit `SELF_BIT` of `clk_mask` is always 0 (clock enabled), both after capture and after a configuration write.
- R9: A `cfg_wr` pulse while `done`=1 loads `cfg_wdata` into `clk_mask`, with bit `SELF_BIT` still forced to 0. A `cfg_wr` pulse while `done`=0 has no effect.
- R10: Primary reset low at any time clears `clk_mask` to 0 and `done`/`busy` to 0. After release, the whole sequence runs again from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| prst_n | input | 1 | Primary reset, active low, asynchronous |
| sec_rst_sense_n | input | 1 | Sensed level of the secondary reset line, active low |
| sw_sec_rst | input | 1 | Software secondary-reset control bit |
| ser_in | input | 1 | Input level of the serial-data GPIO pin |
| gpio_reg_out | input | GPIO_W | Output values from the GPIO registers |
| gpio_reg_oe | input | GPIO_W | Output enables from the GPIO registers |
| gpio_out | output | GPIO_W | GPIO pin output values |
| gpio_oe | output | GPIO_W | GPIO pin output enables |
| cfg_wr | input | 1 | Configuration write strobe for the clock control register |
| cfg_wdata | input | MASK_W | Configuration write data |
| clk_mask | output | MASK_W | Secondary-clock disable mask, 1 = disabled |
| sec_rst_n | output | 1 | Secondary reset release, active low |
| busy | output | 1 | Load or shift in progress |
| done | output | 1 | Mask captured, pins released |

## Verification
The bench builds the block with `MASK_W`=12 and `SELF_BIT`=5, keeping four GPIO pins with the load pin at 2 and the shift clock at 0. A width that is not a power of two exposes a shift counter that stops at a wrong count. Placing the forced bit inside the middle nibble means a wrong bit index changes the patterns in the table. An asymmetric pattern such as 0xA5C tells most-significant-first order apart from the reverse, and a pattern whose only set bit is the forced one shows the forcing in isolation.

// File: rtl/clkmask_pkg.sv
package clkmask_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_DONE
    } ld_state_e;

endpackage

// File: rtl/clkmask_fsm.sv
module clkmask_fsm
    import clkmask_pkg::*;
#(
    parameter int MASK_W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sense_n,
    output ld_state_e state,
    output logic      capture,
    output logic      finish
);

    localparam int CNT_W = $clog2(MASK_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MASK_W);

    ld_state_e        nxt;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_SHIFT_LO) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (!sense_n) nxt = ST_LOAD;
            ST_LOAD:     nxt = ST_SHIFT_LO;
            ST_SHIFT_LO: nxt = ST_SHIFT_HI;
            ST_SHIFT_HI: nxt = (cnt == CNT_LAST) ? ST_DONE : ST_SHIFT_LO;
            ST_DONE:     nxt = ST_DONE;
            default:     nxt = ST_IDLE;
        endcase
    end

    assign capture = (state == ST_SHIFT_LO);
    assign finish  = (state == ST_SHIFT_HI) && (cnt == CNT_LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST) else $error("shift count overran"); // R3

    AST_LOAD_TO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state == ST_SHIFT_LO)) else $error("load not single"); // R2

endmodule

// File: rtl/clkmask_shifter.sv
module clkmask_shifter #(
    parameter int MASK_W   = 16,
    parameter int SELF_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              finish,
    input  logic              ser_in,
    input  logic              done,
    input  logic              cfg_wr,
    input  logic [MASK_W-1:0] cfg_wdata,
    output logic [MASK_W-1:0] clk_mask
);

    localparam logic [MASK_W-1:0] SELF_CLR = ~(MASK_W'(1) << SELF_BIT);

    logic [MASK_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            clk_mask <= '0;
        end else begin
            if (capture) begin
                shreg <= {shreg[MASK_W-2:0], ser_in};
            end
            if (finish) begin
                clk_mask <= shreg & SELF_CLR;
            end else if (done && cfg_wr) begin
                clk_mask <= cfg_wdata & SELF_CLR;
            end
        end
    end

    AST_SELF_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_mask[SELF_BIT]) else $error("self clock bit set"); // R8

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!finish && !(done && cfg_wr)) |=> $stable(clk_mask)) else $error("mask moved"); // R5

endmodule

// File: rtl/clkmask_pinmux.sv
module clkmask_pinmux #(
    parameter int GPIO_W   = 4,
    parameter int LD_PIN   = 2,
    parameter int SCLK_PIN = 0
) (
    input  logic              seq_mode,
    input  logic              ld_lvl,
    input  logic              sclk_lvl,
    input  logic [GPIO_W-1:0] reg_out,
    input  logic [GPIO_W-1:0] reg_oe,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_oe
);

    for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
        if (i == LD_PIN) begin : g_ld
            assign gpio_out[i] = seq_mode ? ld_lvl : reg_out[i];
            assign gpio_oe[i]  = seq_mode | reg_oe[i];
        end else if (i == SCLK_PIN) begin : g_sclk
            assign gpio_out[i] = seq_mode ? sclk_lvl : reg_out[i];
            assign gpio_oe[i]  = seq_mode | reg_oe[i];
        end else begin : g_other
            assign gpio_out[i] = reg_out[i];
            assign gpio_oe[i]  = seq_mode ? 1'b0 : reg_oe[i];
        end
    end

endmodule

// File: rtl/clkmask_loader.sv
module clkmask_loader
    import clkmask_pkg::*;
#(
    parameter int MASK_W   = 16,
    parameter int SELF_BIT = 1,
    parameter int GPIO_W   = 4,
    parameter int LD_PIN   = 2,
    parameter int SCLK_PIN = 0
) (
    input  logic              clk,
    input  logic              prst_n,
    input  logic              sec_rst_sense_n,
    input  logic              sw_sec_rst,
    input  logic              ser_in,
    input  logic [GPIO_W-1:0] gpio_reg_out,
    input  logic [GPIO_W-1:0] gpio_reg_oe,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_oe,
    input  logic              cfg_wr,
    input  logic [MASK_W-1:0] cfg_wdata,
    output logic [MASK_W-1:0] clk_mask,
    output logic              sec_rst_n,
    output logic              busy,
    output logic              done
);

    ld_state_e state;
    logic      capture;
    logic      finish;
    logic      ld_lvl;
    logic      sclk_lvl;

    clkmask_fsm #(.MASK_W(MASK_W)) u_fsm (
        .clk     (clk),
        .rst_n   (prst_n),
        .sense_n (sec_rst_sense_n),
        .state   (state),
        .capture (capture),
        .finish  (finish)
    );

    clkmask_shifter #(.MASK_W(MASK_W), .SELF_BIT(SELF_BIT)) u_shift (
        .clk       (clk),
        .rst_n     (prst_n),
        .capture   (capture),
        .finish    (finish),
        .ser_in    (ser_in),
        .done      (done),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .clk_mask  (clk_mask)
    );

    // state-decoded outputs
    always_comb begin
        ld_lvl   = 1'b1;
        sclk_lvl = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_LOAD:     begin ld_lvl = 1'b0; busy = 1'b1; end
            ST_SHIFT_LO: busy = 1'b1;
            ST_SHIFT_HI: begin sclk_lvl = 1'b1; busy = 1'b1; end
            ST_DONE:     done = 1'b1;
            default:     ;
        endcase
    end

    assign sec_rst_n = done & ~sw_sec_rst;

    clkmask_pinmux #(.GPIO_W(GPIO_W), .LD_PIN(LD_PIN), .SCLK_PIN(SCLK_PIN)) u_pins (
        .seq_mode (~done),
        .ld_lvl   (ld_lvl),
        .sclk_lvl (sclk_lvl),
        .reg_out  (gpio_reg_out),
        .reg_oe   (gpio_reg_oe),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe)
    );

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!prst_n)
        (!done && !gpio_out[LD_PIN]) |=> gpio_out[LD_PIN]) else $error("load low twice"); // R2

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!prst_n)
        !done |-> !sec_rst_n) else $error("secondary reset released early"); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!prst_n)
        done |=> (done && !busy)) else $error("done dropped"); // R5

    AST_PINS_RELEASED: assert property (@(posedge clk) disable iff (!prst_n)
        done |-> (gpio_oe == gpio_reg_oe)) else $error("pins not released"); // R7

endmodule

// File: tb/sim_clkmask_loader.sv
`timescale 1ns/1ps
module sim_clkmask_loader;

    localparam int MW = 12;
    localparam int SB = 5;
    localparam int GW = 4;
    localparam int LD = 2;
    localparam int SC = 0;
    localparam int NV = 6;

    localparam logic [MW-1:0] VEC_PAR [NV] = '{12'hFFF, 12'h000, 12'hA5C, 12'h801, 12'h3E7, 12'h020};
    localparam logic [MW-1:0] VEC_EXP [NV] = '{12'hFDF, 12'h000, 12'hA5C, 12'h801, 12'h3C7, 12'h000};

    logic          clk = 1'b0;
    logic          prst_n = 1'b0;
    logic          sense_n = 1'b1;
    logic          sw_sec_rst = 1'b0;
    logic          ser_in;
    logic [GW-1:0] reg_out = '0;
    logic [GW-1:0] reg_oe = '0;
    logic [GW-1:0] gpio_out, gpio_oe;
    logic          cfg_wr = 1'b0;
    logic [MW-1:0] cfg_wdata = '0;
    logic [MW-1:0] clk_mask;
    logic          sec_rst_n, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    clkmask_loader #(.MASK_W(MW), .SELF_BIT(SB), .GPIO_W(GW), .LD_PIN(LD), .SCLK_PIN(SC)) u0 (
        .clk(clk), .prst_n(prst_n), .sec_rst_sense_n(sense_n), .sw_sec_rst(sw_sec_rst),
        .ser_in(ser_in), .gpio_reg_out(reg_out), .gpio_reg_oe(reg_oe),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .clk_mask(clk_mask), .sec_rst_n(sec_rst_n), .busy(busy), .done(done)
    );

    // behavioural external parallel-in/serial-out register
    logic [MW-1:0] par_val = '0;
    logic [MW-1:0] ext_reg = '0;
    logic          frc_en = 1'b0;
    logic          frc_val = 1'b0;
    always @(negedge gpio_out[LD] or posedge gpio_out[SC]) begin
        if (!gpio_out[LD]) ext_reg <= par_val;
        else               ext_reg <= {ext_reg[MW-2:0], 1'b0};
    end
    assign ser_in = frc_en ? frc_val : ext_reg[MW-1];

    // pin activity monitor
    logic mon_clr = 1'b1;
    int   ld_low_cnt, sclk_rise_cnt;
    logic sclk_prev;
    always @(negedge clk) begin
        if (mon_clr) begin
            ld_low_cnt = 0; sclk_rise_cnt = 0; sclk_prev = 1'b0;
        end else begin
            if (gpio_oe[LD] && !gpio_out[LD]) ld_low_cnt++;
            if (gpio_out[SC] && !sclk_prev) sclk_rise_cnt++;
            sclk_prev = gpio_out[SC];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic restart(input logic [MW-1:0] par);
        @(negedge clk);
        prst_n = 1'b0; sense_n = 1'b1; par_val = par; mon_clr = 1'b1; frc_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prst_n = 1'b1; mon_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // runs a full sequence from idle; write_mid issues a cfg write during shifting
    task automatic run_seq(input logic [MW-1:0] exp, input bit write_mid);
        chk("R1 idle busy", {31'b0, busy}, 32'd0);
        chk("R1 idle load pin high", {31'b0, gpio_out[LD]}, 32'd1);
        sense_n = 1'b0;
        @(negedge clk);
        chk("R2 load pin low", {31'b0, gpio_out[LD]}, 32'd0);
        chk("R7 oe during sequence", {28'b0, gpio_oe}, 32'h5);
        chk("R6 held in reset", {31'b0, sec_rst_n}, 32'd0);
        for (int k = 0; k < 2 * MW; k++) begin
            @(negedge clk);
            if (write_mid && k == 5) cfg_wr = 1'b1;
            else cfg_wr = 1'b0;
        end
        cfg_wr = 1'b0;
        chk("R3 not done before last clock", {31'b0, done}, 32'd0);
        @(negedge clk);
        chk("R3 done on time", {31'b0, done}, 32'd1);
        chk("R2 one load cycle", ld_low_cnt, 32'd1);
        chk("R3 shift clock count", sclk_rise_cnt, MW);
        chk(write_mid ? "R9 write while busy ignored" : "R4 captured mask MSB first", {20'b0, clk_mask}, {20'b0, exp});
    endtask

    initial begin
        // reset state
        #1;
        chk("R10 reset done", {31'b0, done}, 32'd0);
        chk("R10 reset mask", {20'b0, clk_mask}, 32'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            restart(VEC_PAR[v]);
            run_seq(VEC_EXP[v], 1'b0);
        end

        // R5: serial input ignored after done
        frc_en = 1'b1; frc_val = 1'b1;
        repeat (4) @(negedge clk);
        frc_val = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 mask unchanged", {20'b0, clk_mask}, 32'h000);
        chk("R5 done stays", {30'b0, done, busy}, 32'd2);

        // R6: release follows software bit
        chk("R6 released", {31'b0, sec_rst_n}, 32'd1);
        sw_sec_rst = 1'b1; #1;
        chk("R6 software hold", {31'b0, sec_rst_n}, 32'd0);
        sw_sec_rst = 1'b0; #1;

        // R7: pins back under register control
        reg_out = 4'b1010; reg_oe = 4'b0110; #1;
        chk("R7 gpio out", {28'b0, gpio_out}, 32'hA);
        chk("R7 gpio oe", {28'b0, gpio_oe}, 32'h6);
        reg_out = '0; reg_oe = '0;

        // R8/R9: configuration write after done
        @(negedge clk);
        cfg_wdata = 12'hFFF; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R8 write forces self bit", {20'b0, clk_mask}, 32'hFDF);
        cfg_wdata = 12'h123; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R9 write replaces mask", {20'b0, clk_mask}, 32'h103);

        // R9: write during shifting has no effect
        cfg_wdata = 12'h000;
        restart(12'hA5C);
        run_seq(12'hA5C, 1'b1);

        // R10: primary reset mid-shift restarts
        restart(12'h3E7);
        sense_n = 1'b0;
        repeat (6) @(negedge clk);
        prst_n = 1'b0; #1;
        chk("R10 abort clears state", {30'b0, done, busy}, 32'd0);
        chk("R10 abort clears mask", {20'b0, clk_mask}, 32'd0);
        restart(12'h801);
        run_seq(12'h801, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule